// File: doc/BRIEF.md
# Multi-Output Clock Divider Controller

This block turns one fast reference clock into a family of related divided clocks: a host clock, a memory reference clock with its inverted partner, a group of 66 MHz outputs, a group of 33 MHz outputs, a 48 MHz output group and a reference output. The fast clock is taken to run at twelve times the 33 MHz rate. The host, memory reference, 66 MHz and 33 MHz outputs are decoded from one shared phase counter, so their edges stay in a fixed relation. The 48 MHz and reference outputs follow their own source inputs, which are brought into the fast domain through synchronisers.

A three-bit mode word picks the rates. It is formed from a host-rate select input and two strap bits that are sampled only while reset is held. One mode disables every driver. Another mode derives every output from an external test clock. An active-low power-down input passes through a two-flop synchroniser. Each output then stops low at the end of its current high phase, and it restarts only at the start of a full high phase. A change of the host-rate select clears the shared phase counter, so all dividers restart together.

Top module: `multiclk_div_ctrl`

## Requirements
- R1: While reset is high, every clock output and the output-enable are low.
- R2: With select=1 and the straps not both 1, the host output is high 1 and low 2 fast cycles (/3). The memory reference output is high 3 and low 3 (/6).
- R3: With select=0 and the straps not both 1, the host output is high 2 and low 2 (/4). The memory reference output is high 4 and low 4 (/8).
- R4: In both run modes, every 66 MHz output is high 3 and low 3 (/6) and every 33 MHz output is high 6 and low 6 (/12). All outputs of a group switch together.
- R5: The inverted memory reference output has the memory reference period with its high and low times swapped. The two outputs are never high together.
- R6: In run modes, each rising edge of a 33 MHz output comes exactly LEAD_33 fast cycles (default 1) after a rising edge of the 66 MHz group.
- R7: The strap bits are captured only while reset is high. A later change on the strap inputs has no effect on the mode.
- R8: Mode {select=0, A=1, B=1} drives output-enable low and keeps every clock output low. Whenever output-enable is low, all clock outputs are low.
- R9: Mode {select=1, A=1, B=1} is test mode. In this mode the host, memory reference and 48 MHz outputs are the test clock /2, the 66 MHz group is /4, the 33 MHz group is /8 and the reference output follows the test clock.
- R10: Once power-down is low, all clock outputs fall low within a bounded time and stay low while it remains low.
- R11: Entering and leaving power-down produces no short pulse. Every high pulse keeps its normal length and no low pulse is shorter than normal.
- R12: After a change of the select input while running, the outputs take the new rates and the R6 edge relation holds again.
- R13: In run modes, the 48 MHz outputs and the reference output follow the synchronised levels of their source inputs, so their high and low times match those of the sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset; the straps are sampled while it is high |
| sel133_i | input | 1 | Host-rate select: 1 = 133 MHz host, 0 = 100 MHz host |
| strap_a_i | input | 1 | Strap bit A |
| strap_b_i | input | 1 | Strap bit B |
| pwrdn_n_i | input | 1 | Active-low power-down request |
| test_clk_i | input | 1 | External test clock, used in test mode |
| usb_src_i | input | 1 | Source level for the 48 MHz outputs |
| ref_src_i | input | 1 | Source level for the reference output |
| host_o | output | 1 | Host clock |
| mref_o | output | 1 | Memory reference clock |
| mref_b_o | output | 1 | Inverted memory reference clock |
| c66_o | output | N66 | 66 MHz group |
| c33_o | output | N33 | 33 MHz group |
| c48_o | output | N48 | 48 MHz group |
| ref_o | output | 1 | Reference clock |
| oe_o | output | 1 | Output-enable for all drivers (low = high impedance) |

## Verification
Power-down gating and the divider waveforms act in the same cycles: the power-down request is dropped and raised while every output is toggling at its own rate. Each output is then judged on the lengths of its high and low pulses across both transitions, so a pulse cut short on the way in or on the way out is caught. In the same way, a select change is made while the counters are running. After it, the bench judges the new pulse lengths and the 66-to-33 edge offset.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    // Shared phase counter spans the least common multiple of all divisors.
    localparam int unsigned BASE_PERIOD = 24;
    localparam int unsigned PH_W        = $clog2(BASE_PERIOD);

    localparam int unsigned DIV_HOST_133 = 3;
    localparam int unsigned DIV_HOST_100 = 4;
    localparam int unsigned DIV_MREF_133 = 6;
    localparam int unsigned DIV_MREF_100 = 8;
    localparam int unsigned DIV_66       = 6;
    localparam int unsigned DIV_33       = 12;

    // Test counter: bit0 = /2, bit1 = /4, bit2 = /8 of the test clock.
    localparam int unsigned TCNT_W = 3;

    typedef enum logic [1:0] {
        MODE_RUN100 = 2'd0,
        MODE_RUN133 = 2'd1,
        MODE_HIZ    = 2'd2,
        MODE_TEST   = 2'd3
    } run_mode_e;

    // One raw level per output group before fan-out and gating.
    typedef struct packed {
        logic host;
        logic mref;
        logic mref_b;
        logic c66;
        logic c33;
        logic c48;
        logic refc;
    } raw_set_t;

    function automatic run_mode_e decode_mode(input logic sel133,
                                              input logic sa,
                                              input logic sb);
        run_mode_e m;
        if (sa && sb)
            m = sel133 ? MODE_TEST : MODE_HIZ;
        else
            m = sel133 ? MODE_RUN133 : MODE_RUN100;
        return m;
    endfunction

    // High for the first floor(div/2) phases of each divided period,
    // shifted later by off phases.
    function automatic logic phase_high(input logic [PH_W-1:0] ph,
                                        input int unsigned div,
                                        input int unsigned off);
        int unsigned p;
        p = (int'(ph) + BASE_PERIOD - off) % div;
        return (p < (div / 2));
    endfunction

endpackage

// File: rtl/mcd_sync2.sv
module mcd_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/mcd_phase_gen.sv
module mcd_phase_gen
    import mcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            realign_i,
    output logic [PH_W-1:0] phase_o
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BASE_PERIOD - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || realign_i)
            phase_q <= '0;
        else if (phase_q == PH_LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/mcd_out_gate.sv
module mcd_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic raw_i,
    output logic out_o
);
    logic en_q;
    logic raw_prev_q;
    logic out_q;
    logic en_next;
    logic start_hi;

    assign start_hi = raw_i && !raw_prev_q;

    // Stay enabled while running or while the current high phase lasts;
    // start again only at the first cycle of a high phase.
    always_comb begin
        if (en_q)
            en_next = run_i || raw_i;
        else
            en_next = run_i && start_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            raw_prev_q <= 1'b0;
            out_q      <= 1'b0;
        end else begin
            en_q       <= en_next;
            raw_prev_q <= raw_i;
            out_q      <= raw_i && en_next;
        end
    end

    assign out_o = out_q;
endmodule

// File: rtl/multiclk_div_ctrl.sv
module multiclk_div_ctrl
    import mcd_pkg::*;
#(
    parameter int unsigned N66     = 4,
    parameter int unsigned N33     = 10,
    parameter int unsigned N48     = 2,
    parameter int unsigned LEAD_33 = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel133_i,
    input  logic           strap_a_i,
    input  logic           strap_b_i,
    input  logic           pwrdn_n_i,
    input  logic           test_clk_i,
    input  logic           usb_src_i,
    input  logic           ref_src_i,
    output logic           host_o,
    output logic           mref_o,
    output logic           mref_b_o,
    output logic [N66-1:0] c66_o,
    output logic [N33-1:0] c33_o,
    output logic [N48-1:0] c48_o,
    output logic           ref_o,
    output logic           oe_o
);
    localparam int unsigned NSYNC   = 5;
    localparam int unsigned IDX_C66 = 3;
    localparam int unsigned IDX_C33 = IDX_C66 + N66;
    localparam int unsigned IDX_C48 = IDX_C33 + N33;
    localparam int unsigned IDX_REF = IDX_C48 + N48;
    localparam int unsigned NOUT    = IDX_REF + 1;

    // Synchronised inputs
    logic [NSYNC-1:0] sync_d;
    logic [NSYNC-1:0] sync_q;
    logic s_sel, s_pwr_n, s_tclk, s_usb, s_ref;

    assign sync_d = {ref_src_i, usb_src_i, test_clk_i, pwrdn_n_i, sel133_i};

    mcd_sync2 #(.W(NSYNC)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (sync_d),
        .q_o (sync_q)
    );

    assign {s_ref, s_usb, s_tclk, s_pwr_n, s_sel} = sync_q;

    // Straps follow their pins only while reset is high
    logic [1:0] strap_q;
    always_ff @(posedge clk) begin
        if (rst)
            strap_q <= {strap_a_i, strap_b_i};
    end

    run_mode_e mode;
    assign mode = decode_mode(s_sel, strap_q[1], strap_q[0]);

    // Realignment on host-rate change
    logic sel_prev_q;
    logic realign;
    always_ff @(posedge clk) begin
        if (rst)
            sel_prev_q <= 1'b0;
        else
            sel_prev_q <= s_sel;
    end
    assign realign = (s_sel != sel_prev_q);

    logic [PH_W-1:0] phase;
    mcd_phase_gen phase_i (
        .clk       (clk),
        .rst       (rst),
        .realign_i (realign),
        .phase_o   (phase)
    );

    // Test-clock divider
    logic              tclk_prev_q;
    logic [TCNT_W-1:0] tcnt_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            tclk_prev_q <= 1'b0;
            tcnt_q      <= '0;
        end else begin
            tclk_prev_q <= s_tclk;
            if (s_tclk && !tclk_prev_q)
                tcnt_q <= tcnt_q + 1'b1;
        end
    end

    // Raw group levels per mode
    raw_set_t raw;
    always_comb begin
        raw = '0;
        unique case (mode)
            MODE_RUN133: begin
                raw.host = phase_high(phase, DIV_HOST_133, 0);
                raw.mref = phase_high(phase, DIV_MREF_133, 0);
                raw.c66  = phase_high(phase, DIV_66, 0);
                raw.c33  = phase_high(phase, DIV_33, LEAD_33);
                raw.c48  = s_usb;
                raw.refc = s_ref;
            end
            MODE_RUN100: begin
                raw.host = phase_high(phase, DIV_HOST_100, 0);
                raw.mref = phase_high(phase, DIV_MREF_100, 0);
                raw.c66  = phase_high(phase, DIV_66, 0);
                raw.c33  = phase_high(phase, DIV_33, LEAD_33);
                raw.c48  = s_usb;
                raw.refc = s_ref;
            end
            MODE_TEST: begin
                raw.host = tcnt_q[0];
                raw.mref = tcnt_q[0];
                raw.c66  = tcnt_q[1];
                raw.c33  = tcnt_q[2];
                raw.c48  = tcnt_q[0];
                raw.refc = s_tclk;
            end
            default: raw = '0;
        endcase
        raw.mref_b = (mode == MODE_HIZ) ? 1'b0 : !raw.mref;
    end

    // Fan-out into one vector of output bits
    logic [NOUT-1:0] raw_vec;
    logic [NOUT-1:0] gated_vec;

    always_comb begin
        raw_vec    = '0;
        raw_vec[0] = raw.host;
        raw_vec[1] = raw.mref;
        raw_vec[2] = raw.mref_b;
        for (int i = 0; i < int'(N66); i++) raw_vec[IDX_C66 + i] = raw.c66;
        for (int i = 0; i < int'(N33); i++) raw_vec[IDX_C33 + i] = raw.c33;
        for (int i = 0; i < int'(N48); i++) raw_vec[IDX_C48 + i] = raw.c48;
        raw_vec[IDX_REF] = raw.refc;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_gate
        mcd_out_gate gate_i (
            .clk   (clk),
            .rst   (rst),
            .run_i (s_pwr_n),
            .raw_i (raw_vec[g]),
            .out_o (gated_vec[g])
        );
    end

    logic oe_q;
    always_ff @(posedge clk) begin
        if (rst)
            oe_q <= 1'b0;
        else
            oe_q <= (mode != MODE_HIZ);
    end

    assign host_o   = gated_vec[0];
    assign mref_o   = gated_vec[1];
    assign mref_b_o = gated_vec[2];
    assign c66_o    = gated_vec[IDX_C66 +: N66];
    assign c33_o    = gated_vec[IDX_C33 +: N33];
    assign c48_o    = gated_vec[IDX_C48 +: N48];
    assign ref_o    = gated_vec[IDX_REF];
    assign oe_o     = oe_q;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
    parameter int unsigned N66 = 4,
    parameter int unsigned N33 = 10,
    parameter int unsigned N48 = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           pwrdn_n_i,
    input logic           host_o,
    input logic           mref_o,
    input logic           mref_b_o,
    input logic [N66-1:0] c66_o,
    input logic [N33-1:0] c33_o,
    input logic [N48-1:0] c48_o,
    input logic           ref_o,
    input logic           oe_o
);
    logic any_out;
    assign any_out = host_o || mref_o || mref_b_o || (|c66_o) ||
                     (|c33_o) || (|c48_o) || ref_o;

    logic rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_quiet_R1: assert (!any_out && !oe_o)
                else $error("outputs active during reset");
        end
    end

    assert_mref_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(mref_o && mref_b_o));

    assert_pd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!pwrdn_n_i && $past(!pwrdn_n_i) && $past(!pwrdn_n_i, 2) &&
         $past(!pwrdn_n_i, 3) && !any_out) |=> !any_out);

    assert_hiz_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> !any_out);
endmodule

bind multiclk_div_ctrl mcd_checker #(.N66(N66), .N33(N33), .N48(N48)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pwrdn_n_i (pwrdn_n_i),
    .host_o    (host_o),
    .mref_o    (mref_o),
    .mref_b_o  (mref_b_o),
    .c66_o     (c66_o),
    .c33_o     (c33_o),
    .c48_o     (c48_o),
    .ref_o     (ref_o),
    .oe_o      (oe_o)
);

// File: tb/multiclk_div_ctrl_tb_top.sv
module multiclk_div_ctrl_tb_top;
    localparam int N66 = 4;
    localparam int N33 = 10;
    localparam int N48 = 2;
    localparam int I66 = 3;
    localparam int I33 = I66 + N66;
    localparam int I48 = I33 + N33;
    localparam int IRF = I48 + N48;
    localparam int NB  = IRF + 1;

    // sel, a, b, hostH, hostL, mrefH, mrefL, c66H, c66L, c33H, c33L, c48H, c48L, refH, refL
    localparam int NROW = 6;
    localparam int TBL [NROW][15] = '{
        '{0, 0, 0, 2, 2, 4, 4, 3, 3, 6, 6, 4, 4, 14, 14},
        '{0, 1, 0, 2, 2, 4, 4, 3, 3, 6, 6, 4, 4, 14, 14},
        '{1, 0, 0, 1, 2, 3, 3, 3, 3, 6, 6, 4, 4, 14, 14},
        '{1, 0, 1, 1, 2, 3, 3, 3, 3, 6, 6, 4, 4, 14, 14},
        '{1, 1, 1, 8, 8, 8, 8, 16, 16, 32, 32, 8, 8, 4, 4},
        '{0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic sel133 = 1'b0, sa = 1'b0, sb = 1'b0, pwrdn_n = 1'b1;
    logic tclk = 1'b0, usb = 1'b0, refs = 1'b0;
    logic host_o, mref_o, mref_b_o, ref_o, oe_o;
    logic [N66-1:0] c66_o;
    logic [N33-1:0] c33_o;
    logic [N48-1:0] c48_o;

    initial begin #5; forever #80  usb  = ~usb;  end
    initial begin #5; forever #280 refs = ~refs; end
    initial begin #5; forever #80  tclk = ~tclk; end

    multiclk_div_ctrl #(.N66(N66), .N33(N33), .N48(N48)) dut_i (
        .clk(clk), .rst(rst), .sel133_i(sel133), .strap_a_i(sa), .strap_b_i(sb),
        .pwrdn_n_i(pwrdn_n), .test_clk_i(tclk), .usb_src_i(usb), .ref_src_i(refs),
        .host_o(host_o), .mref_o(mref_o), .mref_b_o(mref_b_o), .c66_o(c66_o),
        .c33_o(c33_o), .c48_o(c48_o), .ref_o(ref_o), .oe_o(oe_o)
    );

    logic [NB-1:0] obs;
    assign obs = {ref_o, c48_o, c33_o, c66_o, mref_b_o, mref_o, host_o};

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Pulse monitor
    logic [NB-1:0] prev = '0;
    int run_len [NB], last_hi [NB], last_lo [NB], edges [NB];
    int exp_hi [NB], exp_lo [NB];
    bit mon_en = 0, lead_en = 0, c66_rose_d = 0;
    int bad_hi = 0, bad_lo = 0, lead_bad = 0, lead_ok = 0, high_seen = 0;

    always @(negedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (obs[b] === prev[b]) begin
                run_len[b]++;
            end else begin
                if (prev[b]) begin
                    last_hi[b] = run_len[b];
                    if (mon_en && edges[b] > 0 && run_len[b] != exp_hi[b]) bad_hi++;
                end else begin
                    last_lo[b] = run_len[b];
                    if (mon_en && edges[b] > 0 && run_len[b] < exp_lo[b]) bad_lo++;
                end
                edges[b]++;
                run_len[b] = 1;
            end
        end
        if (mon_en && lead_en && obs[I33] && !prev[I33]) begin
            if (c66_rose_d) lead_ok++; else lead_bad++;
        end
        c66_rose_d = obs[I66] && !prev[I66];
        if (mon_en && obs != '0) high_seen++;
        prev = obs;
    end

    task automatic clear_mon();
        for (int b = 0; b < NB; b++) begin
            edges[b] = 0; last_hi[b] = 0; last_lo[b] = 0;
        end
        bad_hi = 0; bad_lo = 0; lead_bad = 0; lead_ok = 0; high_seen = 0;
    endtask

    task automatic set_exp(input int r);
        exp_hi[0] = TBL[r][3];  exp_lo[0] = TBL[r][4];
        exp_hi[1] = TBL[r][5];  exp_lo[1] = TBL[r][6];
        exp_hi[2] = TBL[r][6];  exp_lo[2] = TBL[r][5];
        for (int i = 0; i < N66; i++) begin exp_hi[I66+i] = TBL[r][7];  exp_lo[I66+i] = TBL[r][8];  end
        for (int i = 0; i < N33; i++) begin exp_hi[I33+i] = TBL[r][9];  exp_lo[I33+i] = TBL[r][10]; end
        for (int i = 0; i < N48; i++) begin exp_hi[I48+i] = TBL[r][11]; exp_lo[I48+i] = TBL[r][12]; end
        exp_hi[IRF] = TBL[r][13]; exp_lo[IRF] = TBL[r][14];
    endtask

    task automatic chk_eq(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input int b, input int ehi, input int elo, input string tag);
        n_chk++;
        if (edges[b] < 3 || last_hi[b] != ehi || last_lo[b] != elo) begin
            n_fail++;
            $display("FAIL %s bit %0d: actual hi/lo %0d/%0d (edges %0d) expected %0d/%0d",
                     tag, b, last_hi[b], last_lo[b], edges[b], ehi, elo);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_mode(input logic s, input logic a, input logic bb);
        @(negedge clk);
        rst = 1'b1; sel133 = s; sa = a; sb = bb;
        wait_cyc(4);
        rst = 1'b0;
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            run_len[b] = 0; edges[b] = 0; last_hi[b] = 0; last_lo[b] = 0;
            exp_hi[b] = 0; exp_lo[b] = 0;
        end

        // R1: reset state
        wait_cyc(3);
        chk_eq(int'(obs), 0, "R1 outputs in reset");
        chk_eq(int'(oe_o), 0, "R1 oe in reset");

        // Table walk over modes
        for (int r = 0; r < NROW; r++) begin
            bit test_m, hiz_m;
            string tg, tg_grp, tg_aux;
            test_m = (TBL[r][0] == 1) && (TBL[r][1] == 1) && (TBL[r][2] == 1);
            hiz_m  = (TBL[r][0] == 0) && (TBL[r][1] == 1) && (TBL[r][2] == 1);
            tg     = test_m ? "R9" : (hiz_m ? "R8" : ((TBL[r][0] == 1) ? "R2" : "R3"));
            tg_grp = test_m ? "R9" : "R4";
            tg_aux = test_m ? "R9" : "R13";
            apply_mode(TBL[r][0][0], TBL[r][1][0], TBL[r][2][0]);
            wait_cyc(60);
            set_exp(r);
            lead_en = !test_m && !hiz_m;
            clear_mon();
            mon_en = 1;
            wait_cyc(260);
            mon_en = 0;
            if (hiz_m) begin
                chk_eq(int'(oe_o), 0, "R8 oe in high-impedance mode");
                chk_eq(high_seen, 0, "R8 outputs quiet in high-impedance mode");
            end else begin
                chk_eq(int'(oe_o), 1, {tg, " oe active"});
                chk_bit(0, TBL[r][3], TBL[r][4], {tg, " host"});
                chk_bit(1, TBL[r][5], TBL[r][6], {tg, " mref"});
                chk_bit(2, TBL[r][6], TBL[r][5], test_m ? "R9 mref_b" : "R5 mref_b");
                chk_bit(I66, TBL[r][7], TBL[r][8], {tg_grp, " c66 first"});
                chk_bit(I66 + N66 - 1, TBL[r][7], TBL[r][8], {tg_grp, " c66 last"});
                chk_bit(I33, TBL[r][9], TBL[r][10], {tg_grp, " c33 first"});
                chk_bit(I33 + N33 - 1, TBL[r][9], TBL[r][10], {tg_grp, " c33 last"});
                chk_bit(I48, TBL[r][11], TBL[r][12], {tg_aux, " c48"});
                chk_bit(IRF, TBL[r][13], TBL[r][14], {tg_aux, " ref"});
                chk_eq(bad_hi + bad_lo, 0, {tg, " steady pulse lengths"});
                if (lead_en) begin
                    chk_eq(lead_bad, 0, "R6 c33 rise after c66 rise");
                    chk_eq(int'(lead_ok > 0), 1, "R6 c33 rises observed");
                end
            end
        end

        // R7: straps changed after reset have no effect
        apply_mode(1'b0, 1'b1, 1'b1);
        wait_cyc(10);
        sa = 1'b0; sb = 1'b0;
        wait_cyc(100);
        clear_mon();
        mon_en = 1;
        wait_cyc(100);
        mon_en = 0;
        chk_eq(int'(oe_o), 0, "R7 oe after strap change");
        chk_eq(high_seen, 0, "R7 outputs after strap change");

        // R10 / R11: power-down entry and exit in 100 mode
        apply_mode(1'b0, 1'b0, 1'b0);
        wait_cyc(60);
        set_exp(0);
        lead_en = 0;
        clear_mon();
        mon_en = 1;
        wait_cyc(50);
        pwrdn_n = 1'b0;
        wait_cyc(60);
        high_seen = 0;
        wait_cyc(50);
        chk_eq(high_seen, 0, "R10 outputs held low in power-down");
        pwrdn_n = 1'b1;
        wait_cyc(120);
        mon_en = 0;
        chk_eq(bad_hi, 0, "R11 high pulse lengths across power-down");
        chk_eq(bad_lo, 0, "R11 low pulse lengths across power-down");
        chk_bit(0, 2, 2, "R11 host after power-down exit");
        chk_bit(I33, 6, 6, "R11 c33 after power-down exit");

        // R12: select change while running
        apply_mode(1'b0, 1'b0, 1'b0);
        wait_cyc(60);
        sel133 = 1'b1;
        wait_cyc(60);
        set_exp(2);
        lead_en = 1;
        clear_mon();
        mon_en = 1;
        wait_cyc(200);
        mon_en = 0;
        chk_bit(0, 1, 2, "R12 host after select change");
        chk_bit(1, 3, 3, "R12 mref after select change");
        chk_eq(lead_bad, 0, "R12 c66/c33 offset after select change");
        chk_eq(int'(lead_ok > 0), 1, "R12 c33 rises after select change");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule